// File: doc/BRIEF.md
# Two-Level Carry Lookahead Adder

A purely combinational 16-bit adder with a carry input. Every bit position forms a propagate term (the XOR of its operand bits) and a generate term (their AND). The bits are split into four 4-bit groups. Each group uses lookahead to derive its three internal carries from its own carry-in in parallel. Instead of a carry-out, each group hands a group propagate and a group generate upward.

A second lookahead stage applies the same equations to the four group pairs and the adder's carry-in. It produces the carries entering bits 4, 8 and 12 together. It also folds the four pairs into one top-level propagate/generate pair, from which the carry at bit 16 is taken as generate OR (propagate AND carry-in). No lookahead gate needs more than four inputs. The top-level pair is exported so that a wider adder can chain this block through a further lookahead level.

Top module: `cla16_two_level`

## Requirements
- R1: `sum` equals the low 16 bits of the unsigned total `a_in + b_in + c_in`.
- R2: `c_out` equals bit 16 of that 17-bit total.
- R3: `blk_p` is 1 exactly when `a_in` and `b_in` differ in all 16 bit positions, that is when `a_in ^ b_in == 16'hFFFF`.
- R4: `blk_g` is 1 exactly when `a_in + b_in` alone, without the carry-in, exceeds 16'hFFFF.
- R5: When every bit propagates, the carry-in travels the full length. `c_out` then equals `c_in`, and every `sum` bit equals the inverse of `c_in`.
- R6: With both operands and the carry-in at zero, `sum`, `c_out`, `blk_p` and `blk_g` are all 0.
- R7: `blk_p` and `blk_g` are never both 1.
- R8: `c_in` has no effect on `blk_p` or `blk_g`. For fixed operands, both outputs are the same with `c_in` at 0 and at 1.
- R9: The carry into each 4-bit group agrees with the recursive rule: carry into the next group = group generate OR (group propagate AND carry into this group). This holds for all four groups, and for the last group the result is `c_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 16 | First operand |
| b_in | input | 16 | Second operand |
| c_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| c_out | output | 1 | Carry out of bit 15 |
| blk_p | output | 1 | Top-level propagate over all 16 bits |
| blk_g | output | 1 | Top-level generate over all 16 bits |

## Verification
The assertions assume the inputs are 2-state and settle before the outputs are examined, since the block holds no state and has no notion of a valid cycle. The bench therefore drives only defined 0/1 values. It changes the operands once per clock, just after the rising edge, and compares half a period later. The stimulus mixes random operand pairs with chosen patterns: full-length propagate chains, carries that cross group boundaries, and all-zero inputs. Together these reach every carry path through both lookahead levels.

// File: rtl/cla16_two_level.sv
module cla16_two_level (
  input  logic [15:0] a_in,
  input  logic [15:0] b_in,
  input  logic        c_in,
  output logic [15:0] sum,
  output logic        c_out,
  output logic        blk_p,
  output logic        blk_g
);
  localparam int GW = 4;
  localparam int NG = 4;
  localparam int W  = GW * NG;

  logic [W-1:0]  p, g, c;
  logic [NG-1:0] gp, gg;
  logic [NG:0]   gc;

  assign p = a_in ^ b_in;
  assign g = a_in & b_in;

  for (genvar k = 0; k < NG; k++) begin : grp
    localparam int L = k * GW;
    assign c[L]   = gc[k];
    assign c[L+1] = g[L] | (p[L] & gc[k]);
    assign c[L+2] = g[L+1] | (p[L+1] & g[L]) | (p[L+1] & p[L] & gc[k]);
    assign c[L+3] = g[L+2] | (p[L+2] & g[L+1]) | (p[L+2] & p[L+1] & g[L])
                  | (p[L+2] & p[L+1] & p[L] & gc[k]);
    assign gp[k]  = p[L+3] & p[L+2] & p[L+1] & p[L];
    assign gg[k]  = g[L+3] | (p[L+3] & g[L+2]) | (p[L+3] & p[L+2] & g[L+1])
                  | (p[L+3] & p[L+2] & p[L+1] & g[L]);
  end

  assign gc[0] = c_in;
  assign gc[1] = gg[0] | (gp[0] & c_in);
  assign gc[2] = gg[1] | (gp[1] & gg[0]) | (gp[1] & gp[0] & c_in);
  assign gc[3] = gg[2] | (gp[2] & gg[1]) | (gp[2] & gp[1] & gg[0])
               | (gp[2] & gp[1] & gp[0] & c_in);

  assign blk_p = gp[3] & gp[2] & gp[1] & gp[0];
  assign blk_g = gg[3] | (gp[3] & gg[2]) | (gp[3] & gp[2] & gg[1])
               | (gp[3] & gp[2] & gp[1] & gg[0]);
  assign gc[4] = blk_g | (blk_p & c_in);

  assign c_out = gc[4];
  assign sum   = p ^ c;
endmodule

module cla16_two_level_chk (
  input logic [15:0] a_in,
  input logic [15:0] b_in,
  input logic        c_in,
  input logic [15:0] sum,
  input logic        c_out,
  input logic        blk_p,
  input logic        blk_g,
  input logic [3:0]  gp,
  input logic [3:0]  gg,
  input logic [4:0]  gc
);
  logic [16:0] total;
  assign total = {1'b0, a_in} + {1'b0, b_in} + {16'd0, c_in};

  always_comb begin
    a_r1_sum_total: assert ({c_out, sum} == total);
    a_r7_gp_exclusive: assert (!(blk_p && blk_g));
    if (blk_p) begin
      a_r5_full_chain: assert (c_out == c_in && sum == {16{~c_in}});
    end
    for (int k = 0; k < 4; k++) begin
      a_r9_group_link: assert (gc[k+1] == (gg[k] | (gp[k] & gc[k])));
    end
  end
endmodule

bind cla16_two_level cla16_two_level_chk i_chk (
  .a_in(a_in), .b_in(b_in), .c_in(c_in), .sum(sum), .c_out(c_out),
  .blk_p(blk_p), .blk_g(blk_g), .gp(gp), .gg(gg), .gc(gc)
);

// File: tb/test_cla16_two_level.sv
module test_cla16_two_level;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0, b_in = '0;
  logic        c_in = 1'b0;
  logic [15:0] sum;
  logic        c_out, blk_p, blk_g;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [15:0] s;
    logic        co;
    logic        p;
    logic        g;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  cla16_two_level i_cla16_two_level (
    .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .sum(sum), .c_out(c_out), .blk_p(blk_p), .blk_g(blk_g)
  );

  function automatic exp_t model(input logic [15:0] a, input logic [15:0] b, input logic ci);
    exp_t e;
    int unsigned t, t0;
    t    = int'(a) + int'(b) + int'(ci);
    t0   = int'(a) + int'(b);
    e.s  = t[15:0];
    e.co = t[16];
    e.p  = ((a ^ b) == 16'hFFFF);
    e.g  = (t0 > 32'hFFFF);
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic ci);
    exp_t e;
    @(posedge clk);
    a_in = a; b_in = b; c_in = ci;
    q.push_back(model(a, b, ci));
    @(negedge clk);
    e = q.pop_front();
    chk(sum == e.s,    "R1", "sum",   int'(sum),   int'(e.s));
    chk(c_out == e.co, "R2", "c_out", int'(c_out), int'(e.co));
    chk(blk_p == e.p,  "R3", "blk_p", int'(blk_p), int'(e.p));
    chk(blk_g == e.g,  "R4", "blk_g", int'(blk_g), int'(e.g));
    chk(!(blk_p && blk_g), "R7", "p&g", int'({blk_p, blk_g}), 0);
  endtask

  task automatic cin_free(input logic [15:0] a, input logic [15:0] b);
    logic p0, g0;
    apply(a, b, 1'b0);
    p0 = blk_p; g0 = blk_g;
    apply(a, b, 1'b1);
    chk(blk_p == p0 && blk_g == g0, "R8", "p/g vs c_in", int'({blk_p, blk_g}), int'({p0, g0}));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sum == 16'h0 && !c_out && !blk_p && !blk_g, "R6", "reset zero",
        int'({c_out, blk_p, blk_g, sum}), 0);
    rst = 1'b0;

    apply(16'h0000, 16'h0000, 1'b0);
    chk(sum == 16'h0 && !c_out && !blk_p && !blk_g, "R6", "all zero",
        int'({c_out, blk_p, blk_g, sum}), 0);
    apply(16'hFFFF, 16'h0001, 1'b0);
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk(sum == 16'h0000 && c_out, "R5", "chain cin=1", int'({c_out, sum}), 32'h10000);
    apply(16'hF0F0, 16'h0F0F, 1'b0);
    chk(sum == 16'hFFFF && !c_out && blk_p, "R5", "chain cin=0", int'({blk_p, c_out, sum}), 32'h2FFFF);
    apply(16'h0FFF, 16'h0001, 1'b0);
    apply(16'h00FF, 16'h0000, 1'b1);
    apply(16'h000F, 16'h0000, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h7FFF, 16'h0000, 1'b1);
    cin_free(16'hAAAA, 16'h5555);
    cin_free(16'hFFFF, 16'h0001);
    cin_free(16'h1234, 16'h4321);
    for (int i = 0; i < 3000; i++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    for (int i = 0; i < 200; i++) begin
      logic [15:0] r;
      r = 16'($urandom);
      apply(r, ~r, 1'($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule